// File: doc/BRIEF.md
# Storage Host Controller Register File with Interrupt Aggregation

This block is the software-visible register file of a multi-port serial storage host controller. A 32-bit, word-aligned write port and a combinational read port reach one small global window and, above it, one 128-byte window per port. Each port window holds an interrupt cause register, an interrupt enable, a command/status register, a read-only view of the attached device's task-file bytes, and link status, control, error, active and command-issue registers.

Outside logic supplies each port's device-present flag, task-file status and error bytes, and one-cycle pulses for new interrupt causes and link errors. The block merges every port's enabled causes into a global status word and one level interrupt output. It sends a one-cycle reset pulse to a port when software lowers that port's link detect field from 1 to 0, and to all ports on a controller reset.

A two-state controller sequencer (CS_RUN, CS_RESET) owns the soft reset. Transition RUN_TO_RESET fires when a global control write has bit 0 set. Transition RESET_TO_RUN always follows one cycle later. During that cycle, register writes and event pulses are dropped, and every register is loaded with its reset value.

Top module: `hba_regblock`

## Requirements
- R1: A write whose address has bits 1:0 not equal to zero changes no register.
- R2: Port p owns byte addresses 0x100 + 128*p up to 0x17F + 128*p. Word offsets are: 0x00 cause, 0x04 enable, 0x08 command, 0x0C task-file, 0x10 link status, 0x14 link control, 0x18 link error, 0x1C active, 0x20 command issue. Addresses of ports at or beyond NPORTS read 0 and ignore writes.
- R3: The port cause register clears the bits written as 1. Event pulses OR new bits in. When a clear and an event hit the same bit in the same cycle, the bit ends set.
- R4: A write to the port enable register stores wdata AND 0xFDC000FF.
- R5: Global status (address 0x04) bit p is 1 exactly when port p has a bit set in both cause and enable. The register is read-only.
- R6: `irq` is high exactly when the global status is nonzero and global control bit 1 (interrupt enable) is set.
- R7: Global control (address 0x00) resets to 0x80000000. A write with bit 0 clear stores bit 1. Bit 31 always reads 1, and every other bit reads 0.
- R8: A global control write with bit 0 set enters CS_RESET for one cycle. The following cycle then shows: interrupt enable 0; each port's cause, enable, link control, link error, active and command issue registers 0; the command register 0x00000006; and `port_rst` all ones for one cycle.
- R9: In the command register, bit 15 mirrors bit 0 and bit 14 mirrors bit 4 of the last write. Written values of bits 15 and 14 are ignored. All other bits are stored.
- R10: The task-file register reads {16'h0, error byte, status byte} from the port's inputs.
- R11: Link status reads 0x00000113 when the port's device is present and 0 otherwise.
- R12: A link control write that changes bits 3:0 from 1 to 0 raises that port's `port_rst` for the next cycle only, and clears its link error and active registers.
- R13: Link error is write-1-to-clear, with external error pulses ORed in. Active and command-issue registers OR in written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| dev_present | input | NPORTS | Device attached, per port |
| tf_status | input | 8*NPORTS | Task-file status byte, per port |
| tf_error | input | 8*NPORTS | Task-file error byte, per port |
| irq_evt | input | 32*NPORTS | Interrupt cause pulses, per port |
| lerr_evt | input | 32*NPORTS | Link error pulses, per port |
| irq | output | 1 | Level interrupt |
| port_rst | output | NPORTS | One-cycle port reset pulses |

## Verification
Some properties are checked by assertions on every cycle:
- the enable register never holds masked bits;
- a cleared cause bit stays clear unless an event sets it again;
- the list-running bit tracks the start bit after each command write;
- a detect 1-to-0 write yields a reset pulse;
- a misaligned write leaves global control untouched;
- the interrupt never rises while disabled.

Other behaviour can only be shown by the bench's scenarios:
- the address map, including out-of-range ports;
- the read-only task-file and link status views;
- the event-versus-clear race;
- the full soft-reset image across all ports.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;

    localparam int unsigned DATA_W         = 32;
    localparam int unsigned PORT_BASE      = 256;
    localparam int unsigned PORT_SPAN_LOG2 = 7;
    localparam int unsigned PWORD_W        = PORT_SPAN_LOG2 - 2;

    // word offsets inside one port window
    typedef enum logic [PWORD_W-1:0] {
        PW_CAUSE  = 5'd0,
        PW_ENABLE = 5'd1,
        PW_CMD    = 5'd2,
        PW_TFILE  = 5'd3,
        PW_LSTAT  = 5'd4,
        PW_LCTL   = 5'd5,
        PW_LERR   = 5'd6,
        PW_LACT   = 5'd7,
        PW_CISSUE = 5'd8
    } port_word_e;

    typedef enum logic {
        CS_RUN   = 1'b0,
        CS_RESET = 1'b1
    } ctl_state_e;

    localparam logic [DATA_W-1:0] ENABLE_KEEP = 32'hFDC0_00FF;
    localparam logic [DATA_W-1:0] CMD_INIT    = 32'h0000_0006;
    localparam logic [DATA_W-1:0] LINK_UP_VAL = 32'h0000_0113;

    localparam int unsigned CMD_START_B = 0;
    localparam int unsigned CMD_RXEN_B  = 4;
    localparam int unsigned CMD_RXRUN_B = 14;
    localparam int unsigned CMD_LRUN_B  = 15;

    localparam int unsigned GC_RESET_B  = 0;
    localparam int unsigned GC_IEN_B    = 1;
    localparam int unsigned GC_MODE_B   = 31;

    localparam int unsigned DET_W       = 4;

endpackage

// File: rtl/hba_port_regs.sv
module hba_port_regs
    import hba_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_clr,
    input  logic                 wr_en,
    input  logic [PWORD_W-1:0]   word_idx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 dev_present,
    input  logic [7:0]           tf_status,
    input  logic [7:0]           tf_error,
    input  logic [DATA_W-1:0]    irq_evt,
    input  logic [DATA_W-1:0]    lerr_evt,
    output logic [DATA_W-1:0]    rdata,
    output logic                 pending,
    output logic                 port_rst
);

    logic [DATA_W-1:0] cause_q, enable_q, cmd_q, lctl_q, lerr_q, lact_q, ciss_q;
    logic              prst_q;

    logic we_cause, we_enable, we_cmd, we_lctl, we_lerr, we_lact, we_ciss;
    logic det_fall;
    logic [DATA_W-1:0] cmd_next;

    always_comb begin
        we_cause  = wr_en && (word_idx == PW_CAUSE);
        we_enable = wr_en && (word_idx == PW_ENABLE);
        we_cmd    = wr_en && (word_idx == PW_CMD);
        we_lctl   = wr_en && (word_idx == PW_LCTL);
        we_lerr   = wr_en && (word_idx == PW_LERR);
        we_lact   = wr_en && (word_idx == PW_LACT);
        we_ciss   = wr_en && (word_idx == PW_CISSUE);
        det_fall  = we_lctl && (lctl_q[DET_W-1:0] == DET_W'(1))
                            && (wdata[DET_W-1:0] == '0);
    end

    // running bits follow their enables; software values for them are dropped
    always_comb begin
        cmd_next              = wdata;
        cmd_next[CMD_LRUN_B]  = wdata[CMD_START_B];
        cmd_next[CMD_RXRUN_B] = wdata[CMD_RXEN_B];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q  <= '0;
            enable_q <= '0;
            cmd_q    <= CMD_INIT;
            lctl_q   <= '0;
            lerr_q   <= '0;
            lact_q   <= '0;
            ciss_q   <= '0;
            prst_q   <= 1'b0;
        end else if (soft_clr) begin
            cause_q  <= '0;
            enable_q <= '0;
            cmd_q    <= CMD_INIT;
            lctl_q   <= '0;
            lerr_q   <= '0;
            lact_q   <= '0;
            ciss_q   <= '0;
            prst_q   <= 1'b1;
        end else begin
            cause_q <= (cause_q & ~(we_cause ? wdata : '0)) | irq_evt;
            if (we_enable) enable_q <= wdata & ENABLE_KEEP;
            if (we_cmd)    cmd_q    <= cmd_next;
            if (we_lctl)   lctl_q   <= wdata;
            if (det_fall) begin
                lerr_q <= lerr_evt;
                lact_q <= '0;
            end else begin
                lerr_q <= (lerr_q & ~(we_lerr ? wdata : '0)) | lerr_evt;
                lact_q <= lact_q | (we_lact ? wdata : '0);
            end
            ciss_q <= ciss_q | (we_ciss ? wdata : '0);
            prst_q <= det_fall;
        end
    end

    always_comb begin
        rdata = '0;
        case (word_idx)
            PW_CAUSE:  rdata = cause_q;
            PW_ENABLE: rdata = enable_q;
            PW_CMD:    rdata = cmd_q;
            PW_TFILE:  rdata = {16'h0000, tf_error, tf_status};
            PW_LSTAT:  rdata = dev_present ? LINK_UP_VAL : '0;
            PW_LCTL:   rdata = lctl_q;
            PW_LERR:   rdata = lerr_q;
            PW_LACT:   rdata = lact_q;
            PW_CISSUE: rdata = ciss_q;
            default:   rdata = '0;
        endcase
    end

    assign pending  = |(cause_q & enable_q);
    assign port_rst = prst_q;

    AST_ENABLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q & ~ENABLE_KEEP) == '0); // R4

    AST_CAUSE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        we_cause |=> ((cause_q & $past(wdata) & ~$past(irq_evt)) == '0)); // R3

    AST_LIST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        we_cmd && !soft_clr |=> cmd_q[CMD_LRUN_B] == $past(wdata[CMD_START_B])); // R9

    AST_DET_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        det_fall && !soft_clr |=> prst_q && (lact_q == '0)); // R12

endmodule

// File: rtl/hba_irq_merge.sv
module hba_irq_merge
    import hba_regs_pkg::*;
#(
    parameter int unsigned NPORTS = 4
) (
    input  logic [NPORTS-1:0]  pending,
    input  logic               gie,
    output logic [DATA_W-1:0]  gstat,
    output logic               irq
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < NPORTS) begin : g_live
            assign gstat[b] = pending[b];
        end else begin : g_idle
            assign gstat[b] = 1'b0;
        end
    end

    assign irq = (gstat != '0) && gie;

endmodule

// File: rtl/hba_regblock.sv
module hba_regblock
    import hba_regs_pkg::*;
#(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NPORTS-1:0]        dev_present,
    input  logic [NPORTS*8-1:0]      tf_status,
    input  logic [NPORTS*8-1:0]      tf_error,
    input  logic [NPORTS*DATA_W-1:0] irq_evt,
    input  logic [NPORTS*DATA_W-1:0] lerr_evt,
    output logic                     irq,
    output logic [NPORTS-1:0]        port_rst
);

    localparam int unsigned PIDX_W = ADDR_W - PORT_SPAN_LOG2;

    ctl_state_e state_q, state_d;
    logic       soft_clr;
    logic       gie_q;

    logic              aligned, in_glob, port_hit, wr_ok, gctl_wr;
    logic [ADDR_W-1:0] poff;
    logic [PIDX_W-1:0] pidx;
    logic [5:0]        gword;

    logic [NPORTS-1:0] pwe, pend;
    logic [DATA_W-1:0] prd [NPORTS];
    logic [DATA_W-1:0] gstat;

    // address decode
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        in_glob  = (addr < ADDR_W'(PORT_BASE));
        poff     = addr - ADDR_W'(PORT_BASE);
        pidx     = poff[ADDR_W-1:PORT_SPAN_LOG2];
        gword    = addr[7:2];
        port_hit = !in_glob && (int'(pidx) < int'(NPORTS));
        wr_ok    = wr_en && aligned && (state_q == CS_RUN);
        gctl_wr  = wr_ok && in_glob && (gword == 6'd0);
        for (int p = 0; p < int'(NPORTS); p++)
            pwe[p] = wr_ok && port_hit && (int'(pidx) == p);
    end

    // controller reset sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:   if (gctl_wr && wdata[GC_RESET_B]) state_d = CS_RESET;
            CS_RESET: state_d = CS_RUN;
            default:  state_d = CS_RUN;
        endcase
    end

    // sequencer outputs
    always_comb begin
        soft_clr = 1'b0;
        unique case (state_q)
            CS_RUN:   soft_clr = 1'b0;
            CS_RESET: soft_clr = 1'b1;
            default:  soft_clr = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            gie_q <= 1'b0;
        else if (soft_clr)                     gie_q <= 1'b0;
        else if (gctl_wr && !wdata[GC_RESET_B]) gie_q <= wdata[GC_IEN_B];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        hba_port_regs u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_clr    (soft_clr),
            .wr_en       (pwe[p]),
            .word_idx    (addr[PORT_SPAN_LOG2-1:2]),
            .wdata       (wdata),
            .dev_present (dev_present[p]),
            .tf_status   (tf_status[p*8 +: 8]),
            .tf_error    (tf_error[p*8 +: 8]),
            .irq_evt     (irq_evt[p*DATA_W +: DATA_W]),
            .lerr_evt    (lerr_evt[p*DATA_W +: DATA_W]),
            .rdata       (prd[p]),
            .pending     (pend[p]),
            .port_rst    (port_rst[p])
        );
    end

    hba_irq_merge #(.NPORTS(NPORTS)) u_merge (
        .pending (pend),
        .gie     (gie_q),
        .gstat   (gstat),
        .irq     (irq)
    );

    // read mux
    always_comb begin
        rdata = '0;
        if (in_glob) begin
            if (gword == 6'd0) begin
                rdata             = '0;
                rdata[GC_MODE_B]  = 1'b1;
                rdata[GC_IEN_B]   = gie_q;
            end else if (gword == 6'd1) begin
                rdata = gstat;
            end
        end else if (port_hit) begin
            for (int p = 0; p < int'(NPORTS); p++)
                if (int'(pidx) == p) rdata = prd[p];
        end
    end

    AST_MISALIGNED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr[1:0] != 2'b00) && (state_q == CS_RUN) |=> $stable(gie_q)); // R1

    AST_GCTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        gctl_wr && !wdata[GC_RESET_B] |=> gie_q == $past(wdata[GC_IEN_B])); // R7

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CS_RESET |=> !gie_q && (port_rst == '1) && (state_q == CS_RUN)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie_q && (gstat != '0)); // R6

endmodule

// File: tb/tb_hba_regblock.sv
module tb_hba_regblock;

    localparam int NP = 4;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NP-1:0]     dev_present = 4'b0101;
    logic [NP*8-1:0]   tf_status = {8'h00, 8'h00, 8'hD0, 8'h50};
    logic [NP*8-1:0]   tf_error  = {8'h00, 8'h00, 8'h04, 8'h01};
    logic [NP*32-1:0]  irq_evt = '0;
    logic [NP*32-1:0]  lerr_evt = '0;
    logic              irq;
    logic [NP-1:0]     port_rst;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    hba_regblock #(.NPORTS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dev_present(dev_present), .tf_status(tf_status),
        .tf_error(tf_error), .irq_evt(irq_evt), .lerr_evt(lerr_evt),
        .irq(irq), .port_rst(port_rst)
    );

    typedef struct packed {
        logic        is_wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h8000_0000, 8'd7},  // R7 reset value
        '{1'b0, 12'h004, 32'h0000_0000, 8'd5},  // R5 reset
        '{1'b0, 12'h108, 32'h0000_0006, 8'd8},  // R8 command init
        '{1'b1, 12'h104, 32'hFFFF_FFFF, 8'd4},
        '{1'b0, 12'h104, 32'hFDC0_00FF, 8'd4},  // R4 mask
        '{1'b1, 12'h108, 32'h0000_C000, 8'd9},
        '{1'b0, 12'h108, 32'h0000_0000, 8'd9},  // R9 run bits ignored
        '{1'b1, 12'h108, 32'h0000_0011, 8'd9},
        '{1'b0, 12'h108, 32'h0000_C011, 8'd9},  // R9 both follow
        '{1'b1, 12'h108, 32'h0000_0001, 8'd9},
        '{1'b0, 12'h108, 32'h0000_8001, 8'd9},  // R9 list only
        '{1'b0, 12'h10C, 32'h0000_0150, 8'd10}, // R10 port0
        '{1'b0, 12'h18C, 32'h0000_04D0, 8'd10}, // R10 port1
        '{1'b0, 12'h110, 32'h0000_0113, 8'd11}, // R11 present
        '{1'b0, 12'h190, 32'h0000_0000, 8'd11}, // R11 absent
        '{1'b1, 12'h105, 32'h0000_0000, 8'd1},
        '{1'b0, 12'h104, 32'hFDC0_00FF, 8'd1},  // R1 misaligned dropped
        '{1'b1, 12'h304, 32'hFFFF_FFFF, 8'd2},
        '{1'b0, 12'h304, 32'h0000_0000, 8'd2},  // R2 port beyond count
        '{1'b1, 12'h204, 32'h0000_00FF, 8'd2},
        '{1'b0, 12'h204, 32'h0000_00FF, 8'd2},  // R2 port2 window
        '{1'b1, 12'h11C, 32'h0000_0003, 8'd13},
        '{1'b1, 12'h11C, 32'h0000_0004, 8'd13},
        '{1'b0, 12'h11C, 32'h0000_0007, 8'd13}, // R13 active OR-set
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 8'd5},
        '{1'b0, 12'h004, 32'h0000_0000, 8'd5}   // R5 read-only
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [AW-1:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, "read", rdata, exp);
    endtask

    task automatic pulse(input bit lerr, input int p, input logic [31:0] bits);
        @(negedge clk);
        if (lerr) lerr_evt[p*32 +: 32] = bits;
        else      irq_evt[p*32 +: 32]  = bits;
        @(negedge clk);
        irq_evt = '0; lerr_evt = '0;
    endtask

    initial begin
        #(20 * 100000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(8, "port_rst after reset", 32'(port_rst), 32'h0);
        check(6, "irq after reset", 32'(irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) do_write(VEC[i].a, VEC[i].d);
            else              rd_check(int'(VEC[i].req), VEC[i].a, VEC[i].d);
        end

        // R7: enable interrupts
        do_write(12'h000, 32'h0000_0002);
        rd_check(7, 12'h000, 32'h8000_0002);

        // R5 R6: port2 cause with enable
        pulse(1'b0, 2, 32'h0000_0001);
        rd_check(5, 12'h004, 32'h0000_0004);
        check(6, "irq pending", 32'(irq), 32'h1);
        // R4 R5: masked cause on port0 does not reach global status
        pulse(1'b0, 0, 32'h0000_0100);
        rd_check(3, 12'h100, 32'h0000_0100);
        rd_check(5, 12'h004, 32'h0000_0004);
        // R3: W1C clears port2 cause
        do_write(12'h200, 32'h0000_0001);
        rd_check(3, 12'h200, 32'h0000_0000);
        rd_check(5, 12'h004, 32'h0000_0000);
        check(6, "irq cleared", 32'(irq), 32'h0);
        // R6: disable hides pending
        pulse(1'b0, 2, 32'h0000_0002);
        check(6, "irq re-raised", 32'(irq), 32'h1);
        do_write(12'h000, 32'h0000_0000);
        check(6, "irq disabled", 32'(irq), 32'h0);
        rd_check(5, 12'h004, 32'h0000_0004);

        // R3: event wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h100; wdata = 32'h0000_0100;
        irq_evt[31:0] = 32'h0000_0100;
        @(negedge clk);
        wr_en = 1'b0; irq_evt = '0;
        rd_check(3, 12'h100, 32'h0000_0100);

        // R13: link error W1C and command issue OR-set
        do_write(12'h114, 32'h0000_0001);
        pulse(1'b1, 0, 32'h0000_0008);
        rd_check(13, 12'h118, 32'h0000_0008);
        do_write(12'h118, 32'h0000_0008);
        rd_check(13, 12'h118, 32'h0000_0000);
        do_write(12'h120, 32'h0000_0001);
        do_write(12'h120, 32'h8000_0000);
        rd_check(13, 12'h120, 32'h8000_0001);

        // R12: detect 1 -> 0 pulses port 0 reset
        pulse(1'b1, 0, 32'h0000_0020);
        do_write(12'h114, 32'h0000_0000);
        #1;
        check(12, "port_rst pulse", 32'(port_rst), 32'h1);
        rd_check(12, 12'h118, 32'h0000_0000);
        rd_check(12, 12'h11C, 32'h0000_0000);
        @(negedge clk); #1;
        check(12, "port_rst one cycle", 32'(port_rst), 32'h0);
        do_write(12'h114, 32'h0000_0000);
        #1;
        check(12, "no pulse 0->0", 32'(port_rst), 32'h0);

        // R8: controller reset
        do_write(12'h000, 32'h0000_0002);
        do_write(12'h204, 32'h0000_00FF);
        do_write(12'h000, 32'h0000_0003);
        @(negedge clk); #1;
        check(8, "port_rst all", 32'(port_rst), 32'hF);
        rd_check(8, 12'h000, 32'h8000_0000);
        rd_check(8, 12'h204, 32'h0000_0000);
        rd_check(8, 12'h108, 32'h0000_0006);
        rd_check(8, 12'h120, 32'h0000_0000);
        rd_check(8, 12'h100, 32'h0000_0000);
        @(negedge clk); #1;
        check(8, "port_rst ends", 32'(port_rst), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule